// File: doc/BRIEF.md
# Challenge-Response Debug Access Gate

This block stands between a debug transport and a debug register file and decides which register writes may reach the register file. When the authentication option is enabled, the gate starts locked. A debugger reads a challenge word from the gate, adds a secret that it shares with the chip, and writes the 32-bit sum back to the gate. A correct answer opens the gate. A wrong answer keeps the gate locked and replaces the challenge with a new pseudo-random value, so a failed guess reveals nothing about the next challenge.

While the gate is locked, only two writes are accepted. One is the response word. The other is a control-register write that can change nothing except the module-active bit. Every other write is dropped, and the gate flags it with a one-cycle error pulse. The gate keeps the module-active bit itself. A 0-to-1 transition of that bit restarts the gate: it locks again (if authentication is enabled) and takes a fresh challenge.

The challenge source is a 32-bit maximal-length LFSR that advances on every clock. The held challenge samples the LFSR only on a restart or after a failed attempt.

Top module: `dbg_auth_gate`

## Requirements
- R1: After reset, `active_o` and `wr_err_o` are 0. `authed_o` is 0 when `auth_req_i` is 1, and 1 when `auth_req_i` is 0.
- R2: While `rd_i` is high and `addr_i` equals AUTH_ADDR (default 7'h2A), `rdata_o` shows the held challenge in the same cycle. For any other read address, `rdata_o` is 0.
- R3: A write to AUTH_ADDR whose data equals (challenge + secret_i) mod 2^32 sets `authed_o` from the next cycle onward. This holds also when the sum overflows.
- R4: A write to AUTH_ADDR with any other value, while authentication is required, clears `authed_o` from the next cycle. From that cycle on, the challenge read back is a different value.
- R5: While locked, a write to an address other than CTRL_ADDR (default 7'h21) and AUTH_ADDR leaves `fwd_wr_o` low. Such a write also raises `wr_err_o` for exactly the following cycle.
- R6: While locked, a CTRL_ADDR write updates `active_o` from data bit ACT_BIT (default bit 0) but keeps `ctrl_fields_we_o` low.
- R7: A CTRL_ADDR write that takes `active_o` from 0 to 1 relocks the gate when authentication is required. The same write loads a new challenge, even if the gate was unlocked.
- R8: When `auth_req_i` is 0, writes to AUTH_ADDR have no effect on `authed_o` or on the challenge.
- R9: While unlocked, a write to any address other than CTRL_ADDR and AUTH_ADDR raises `fwd_wr_o` in the same cycle and gives no error pulse. A CTRL_ADDR write with ACT_BIT set raises `ctrl_fields_we_o` in the same cycle.
- R10: The challenge does not change except through a failed attempt or a restart. A successful unlock leaves it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| auth_req_i | input | 1 | 1 = the challenge-response check is enforced |
| secret_i | input | 32 | Hidden secret added to the challenge |
| addr_i | input | 7 | Register address |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Challenge on reads of AUTH_ADDR, 0 otherwise |
| fwd_wr_o | output | 1 | Write passed on to the register file |
| ctrl_fields_we_o | output | 1 | Control fields other than the active bit may update |
| active_o | output | 1 | Module-active bit held by the gate |
| authed_o | output | 1 | Gate unlocked |
| wr_err_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
The bench uses the default parameters: a 7-bit address with CTRL_ADDR 7'h21 and AUTH_ADDR 7'h2A, the active bit at position 0, and a 32-bit LFSR. With a 32-bit data path, the bench sets the secret to all ones to reach the case where challenge plus secret wraps past 2^32. The bench also resets the gate with `auth_req_i` low, which brings the bypass mode into reach.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_CTRL,
    ACC_AUTH,
    ACC_OTHER
  } acc_kind_e;
endpackage

// File: rtl/chal_lfsr.sv
module chal_lfsr #(
  parameter int unsigned         W    = 32,
  parameter logic [W-1:0]        TAPS = 32'h8020_0003,
  parameter logic [W-1:0]        SEED = 32'h1ACE_B00C
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic [W-1:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = {lfsr_q[W-2:0], ^(lfsr_q & TAPS)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= lfsr_d;
  end

  assign state_o = lfsr_q;

  // R10: a nonzero seed keeps the challenge source out of the all-zero lockup state
  assert_lfsr_alive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
endmodule

// File: rtl/auth_core.sv
module auth_core #(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] SEED = 32'h1ACE_B00C
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [W-1:0] secret_i,
  input  logic [W-1:0] lfsr_i,
  input  logic         resp_we_i,
  input  logic [W-1:0] resp_i,
  input  logic         restart_i,
  output logic         authed_o,
  output logic [W-1:0] chal_o
);
  logic         authed_q, authed_d, authed_en;
  logic [W-1:0] chal_q, chal_d;
  logic         chal_en;
  logic [W-1:0] expect_sum;
  logic         match;

  assign expect_sum = chal_q + secret_i;
  assign match      = (expect_sum == resp_i);

  always_comb begin
    authed_en = 1'b0;
    authed_d  = authed_q;
    chal_en   = 1'b0;
    chal_d    = chal_q;
    if (restart_i) begin
      authed_en = 1'b1;
      authed_d  = 1'b0;
      chal_en   = 1'b1;
      chal_d    = lfsr_i;
    end else if (resp_we_i && req_i) begin
      authed_en = 1'b1;
      authed_d  = match;
      if (!match) begin
        chal_en = 1'b1;
        chal_d  = lfsr_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        authed_q <= 1'b0;
    else if (authed_en) authed_q <= authed_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chal_q <= SEED;
    else if (chal_en) chal_q <= chal_d;
  end

  assign authed_o = authed_q | ~req_i;
  assign chal_o   = chal_q;

  // R3: a matching response opens the gate on the next cycle
  assert_match_unlocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_we_i && req_i && !restart_i && (resp_i == chal_q + secret_i)) |=> authed_o);
  // R4: a wrong response locks and re-rolls the challenge
  assert_miss_rerolls_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_we_i && req_i && !restart_i && (resp_i != chal_q + secret_i)) |=>
      (!authed_o && chal_o != $past(chal_o)));
  // R7: a restart under enforcement relocks
  assert_restart_locks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && req_i) |=> !authed_o);
  // R10: the challenge holds when there is neither a failed attempt nor a restart
  assert_chal_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !(resp_we_i && req_i && !match)) |=> $stable(chal_o));
  // R8: in bypass the gate always reads as open
  assert_bypass_open_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> authed_o);
endmodule

// File: rtl/wr_filter.sv
module wr_filter
  import dbg_gate_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 7,
  parameter int unsigned       DW        = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h21,
  parameter logic [ADDR_W-1:0] AUTH_ADDR = 7'h2A,
  parameter int unsigned       ACT_BIT   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              authed_i,
  input  logic              req_i,
  output logic              fwd_wr_o,
  output logic              fields_we_o,
  output logic              resp_we_o,
  output logic              restart_o,
  output logic              active_o,
  output logic              err_o
);
  acc_kind_e kind;
  logic      active_q, active_d, active_en;
  logic      err_q, err_d;
  logic      act_bit;

  always_comb begin
    if (!wr_i)                      kind = ACC_NONE;
    else if (addr_i == CTRL_ADDR)   kind = ACC_CTRL;
    else if (addr_i == AUTH_ADDR)   kind = ACC_AUTH;
    else                            kind = ACC_OTHER;
  end

  assign act_bit = wdata_i[ACT_BIT];

  always_comb begin
    active_en   = (kind == ACC_CTRL);
    active_d    = active_en ? act_bit : active_q;
    restart_o   = (kind == ACC_CTRL) && act_bit && !active_q;
    fields_we_o = (kind == ACC_CTRL) && act_bit &&
                  (restart_o ? !req_i : authed_i);
    resp_we_o   = (kind == ACC_AUTH);
    fwd_wr_o    = (kind == ACC_OTHER) && authed_i;
    err_d       = (kind == ACC_OTHER) && !authed_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        active_q <= 1'b0;
    else if (active_en) active_q <= active_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign active_o = active_q;
  assign err_o    = err_q;

  // R5: a locked gate never forwards a write
  assert_locked_no_fwd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !authed_i |-> !fwd_wr_o);
  // R5: a rejected write is flagged on the next cycle
  assert_reject_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !authed_i && addr_i != CTRL_ADDR && addr_i != AUTH_ADDR) |=> err_o);
  // R6: control fields move only with an open gate
  assert_fields_need_auth_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fields_we_o |-> (authed_i && wr_i));
  // R9: no error follows a write made while open
  assert_open_no_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && authed_i) |=> !err_o);
endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate
  import dbg_gate_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 7,
  parameter int unsigned       DW        = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h21,
  parameter logic [ADDR_W-1:0] AUTH_ADDR = 7'h2A,
  parameter int unsigned       ACT_BIT   = 0,
  parameter logic [DW-1:0]     LFSR_TAPS = 32'h8020_0003,
  parameter logic [DW-1:0]     LFSR_SEED = 32'h1ACE_B00C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              auth_req_i,
  input  logic [DW-1:0]     secret_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DW-1:0]     rdata_o,
  output logic              fwd_wr_o,
  output logic              ctrl_fields_we_o,
  output logic              active_o,
  output logic              authed_o,
  output logic              wr_err_o
);
  logic [DW-1:0] lfsr_state;
  logic [DW-1:0] chal;
  logic          resp_we;
  logic          restart;
  logic          authed;

  chal_lfsr #(.W(DW), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (lfsr_state)
  );

  auth_core #(.W(DW), .SEED(LFSR_SEED)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (auth_req_i),
    .secret_i  (secret_i),
    .lfsr_i    (lfsr_state),
    .resp_we_i (resp_we),
    .resp_i    (wdata_i),
    .restart_i (restart),
    .authed_o  (authed),
    .chal_o    (chal)
  );

  wr_filter #(
    .ADDR_W(ADDR_W), .DW(DW), .CTRL_ADDR(CTRL_ADDR),
    .AUTH_ADDR(AUTH_ADDR), .ACT_BIT(ACT_BIT)
  ) u_filter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .authed_i    (authed),
    .req_i       (auth_req_i),
    .fwd_wr_o    (fwd_wr_o),
    .fields_we_o (ctrl_fields_we_o),
    .resp_we_o   (resp_we),
    .restart_o   (restart),
    .active_o    (active_o),
    .err_o       (wr_err_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i && addr_i == AUTH_ADDR) rdata_o = chal;
  end

  assign authed_o = authed;

  // R2: reads of any register other than the response word return zero
  assert_read_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && addr_i == AUTH_ADDR) |-> rdata_o == '0);
endmodule

// File: tb/test_dbg_auth_gate.sv
`timescale 1ns/1ps
module test_dbg_auth_gate;
  localparam logic [6:0] CTRL = 7'h21;
  localparam logic [6:0] AUTH = 7'h2A;

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_RDNEW = 3'd2,
                         OP_GOOD = 3'd3, OP_BAD = 3'd4;

  // {op, addr, data, exp_fwd, exp_err, exp_authed}
  localparam int NV = 12;
  localparam logic [44:0] VEC [NV] = '{
    {OP_WR,    7'h05, 32'hAAAA_0001, 1'b0, 1'b1, 1'b0},
    {OP_RD,    AUTH,  32'h0,         1'b0, 1'b0, 1'b0},
    {OP_RD,    AUTH,  32'h0,         1'b0, 1'b0, 1'b0},
    {OP_BAD,   AUTH,  32'h0,         1'b0, 1'b0, 1'b0},
    {OP_RDNEW, AUTH,  32'h0,         1'b0, 1'b0, 1'b0},
    {OP_GOOD,  AUTH,  32'h0,         1'b0, 1'b0, 1'b1},
    {OP_WR,    7'h05, 32'h5555_0002, 1'b1, 1'b0, 1'b1},
    {OP_BAD,   AUTH,  32'h0,         1'b0, 1'b0, 1'b0},
    {OP_RDNEW, AUTH,  32'h0,         1'b0, 1'b0, 1'b0},
    {OP_WR,    7'h03, 32'h0000_0003, 1'b0, 1'b1, 1'b0},
    {OP_GOOD,  AUTH,  32'h0,         1'b0, 1'b0, 1'b1},
    {OP_RD,    AUTH,  32'h0,         1'b0, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        auth_req;
  logic [31:0] secret;
  logic [6:0]  addr;
  logic [31:0] wdata;
  logic        wr, rd;
  logic [31:0] rdata;
  logic        fwd_wr, fields_we, active, authed, wr_err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] chal_seen;
  logic        fwd_s, fields_s;

  always #2.5 clk = ~clk;

  dbg_auth_gate i_dbg_auth_gate (
    .clk_i(clk), .rst_ni(rst_n), .auth_req_i(auth_req), .secret_i(secret),
    .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata),
    .fwd_wr_o(fwd_wr), .ctrl_fields_we_o(fields_we), .active_o(active),
    .authed_o(authed), .wr_err_o(wr_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic req, input logic [31:0] sec);
    rst_n = 1'b0; auth_req = req; secret = sec;
    wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    #1;
    fwd_s = fwd_wr; fields_s = fields_we;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_read(output logic [31:0] v);
    @(negedge clk);
    rd = 1'b1; addr = AUTH;
    #1;
    v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected<20000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin : main
    logic [31:0] v, old;
    do_reset(1'b1, 32'h1234_5678);
    // R1 reset state with enforcement
    check("R1 authed", {31'd0, authed}, 32'd0);
    check("R1 active", {31'd0, active}, 32'd0);
    check("R1 err", {31'd0, wr_err}, 32'd0);
    do_read(chal_seen);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  op;
      logic [6:0]  va;
      logic [31:0] vd;
      logic        efwd, eerr, eauth;
      {op, va, vd, efwd, eerr, eauth} = VEC[i];
      case (op)
        OP_WR: begin
          do_write(va, vd);
          check("R5/R9 fwd", {31'd0, fwd_s}, {31'd0, efwd});
          check("R5/R9 err pulse", {31'd0, wr_err}, {31'd0, eerr});
          @(negedge clk);
          check("R5 err one cycle", {31'd0, wr_err}, 32'd0);
        end
        OP_RD: begin
          do_read(v);
          check("R2/R10 challenge stable", v, chal_seen);
        end
        OP_RDNEW: begin
          do_read(v);
          check("R4 challenge rerolled", {31'd0, v != chal_seen}, 32'd1);
          chal_seen = v;
        end
        OP_GOOD: do_write(AUTH, chal_seen + secret);
        default: do_write(AUTH, chal_seen + secret + 32'd7);
      endcase
      check("R3/R4 authed", {31'd0, authed}, {31'd0, eauth});
    end

    // R2: another read address gives zero
    @(negedge clk); rd = 1'b1; addr = CTRL; #1;
    check("R2 other read zero", rdata, 32'd0);
    @(negedge clk); rd = 1'b0;

    // R6/R7: locked control write with field bits; rising active takes a new challenge
    do_reset(1'b1, 32'h1234_5678);
    do_read(chal_seen);
    do_write(CTRL, 32'hFFFF_FFFF);
    check("R6 fields held while locked", {31'd0, fields_s}, 32'd0);
    check("R6 active bit updated", {31'd0, active}, 32'd1);
    do_read(v);
    check("R7 rise draws new challenge", {31'd0, v != chal_seen}, 32'd1);
    chal_seen = v;
    do_write(AUTH, chal_seen + secret);
    check("R3 unlock", {31'd0, authed}, 32'd1);
    do_write(CTRL, 32'h0000_0101);
    check("R9 fields enabled when open", {31'd0, fields_s}, 32'd1);
    do_write(CTRL, 32'h0);
    check("R9 stays open on active clear", {31'd0, authed}, 32'd1);
    do_write(CTRL, 32'h1);
    check("R7 rise relocks", {31'd0, authed}, 32'd0);
    check("R7 fields held on relock", {31'd0, fields_s}, 32'd0);
    do_read(v);
    check("R7 relock new challenge", {31'd0, v != chal_seen}, 32'd1);

    // R3: overflow of challenge + secret wraps
    do_reset(1'b1, 32'hFFFF_FFFF);
    do_read(chal_seen);
    do_write(AUTH, chal_seen - 32'd1);
    check("R3 wrapped sum unlocks", {31'd0, authed}, 32'd1);
    do_read(v);
    check("R10 success keeps challenge", v, chal_seen);

    // R1/R8: bypass mode
    do_reset(1'b0, 32'h1234_5678);
    check("R1 bypass authed", {31'd0, authed}, 32'd1);
    do_read(chal_seen);
    do_write(AUTH, 32'hDEAD_BEEF);
    check("R8 bad response ignored", {31'd0, authed}, 32'd1);
    do_read(v);
    check("R8 challenge untouched", v, chal_seen);
    do_write(7'h05, 32'h1);
    check("R8 bypass forwards", {31'd0, fwd_s}, 32'd1);
    do_write(CTRL, 32'h1);
    check("R8 bypass fields on rise", {31'd0, fields_s}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule